// File: doc/BRIEF.md
# Peak Common-Mode Step Limiter

This block sits beside the arm modulators of a three-phase converter whose legs are built from stacked submodules. Once per switching period it looks at the integer base counts and the fractional PWM remainders of all six arms. From these it decides whether the lower-arm peak and the upper-arm trough in on-count would fall together. When they do, the common-mode step (lower-arm on-count minus upper-arm on-count) reaches plus or minus 2. In that case it produces a pair of opposite offsets for the upper-arm and lower-arm remainders. These offsets pull the two extremes apart, so the step stays within plus or minus 1. Each step is worth Vdc/(6N) volts.

The offsets act only in the sectors where the sums of the base counts of the two arms differ by exactly one. In every other sector both offsets are zero and the modulation passes through unchanged. Each offset is clamped so that no remainder leaves the unit interval. Separately, on every clock the block reports the live common-mode step computed from the two arm on-count totals.

Top module: `peak_cm_limiter`

## Requirements
- R1: While rst_ni is low, mode_o is 2 (idle), off_u_o and off_l_o are 0 and cm_step_o is 0.
- R2: On every clock edge cm_step_o takes on_cnt_l_i minus on_cnt_u_i as a two's complement value of SUM_W+1 bits, visible one cycle after the inputs.
- R3: Let d be the lower-arm base sum minus the upper-arm base sum. If d is -1 and the largest upper remainder is greater than the smallest lower remainder, mode 0 is selected.
- R4: If d is +1 and the largest lower remainder is greater than the smallest upper remainder, mode 1 is selected.
- R5: In every other case mode 2 (idle) is selected and both offsets are zero.
- R6: Let m be floor((smallest upper remainder minus largest lower remainder)/2). Before clamping, mode 0 gives off_u = m and off_l = -m, and mode 1 gives off_u = -m and off_l = m.
- R7: Remainders are unsigned with FRAC_W fraction bits, so 2^FRAC_W stands for 1.0. off_u is clamped into [-min upper remainder, 2^FRAC_W - max upper remainder]. off_l is clamped the same way against the lower-arm remainders.
- R8: Mode and offsets are loaded at a clock edge where strobe_i is high, using the inputs present at that edge. At all other times they hold their value.
- R9: The strobe update and the live step update are independent. When both happen at the same edge, each output takes its own correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Once-per-period evaluate pulse |
| base_u_i | input | 3 x CNT_W | Upper-arm base counts, index = phase |
| base_l_i | input | 3 x CNT_W | Lower-arm base counts, index = phase |
| rem_u_i | input | 3 x REM_W | Upper-arm PWM remainders, 2^FRAC_W = 1.0 |
| rem_l_i | input | 3 x REM_W | Lower-arm PWM remainders, 2^FRAC_W = 1.0 |
| on_cnt_u_i | input | SUM_W | Live upper-arm total on-count |
| on_cnt_l_i | input | SUM_W | Live lower-arm total on-count |
| mode_o | output | 2 | 0: lower-peak case, 1: upper-peak case, 2: idle |
| off_u_o | output | OFF_W | Signed offset for upper-arm remainders |
| off_l_o | output | OFF_W | Signed offset for lower-arm remainders |
| cm_step_o | output | SUM_W+1 | Signed live common-mode step |

## Verification
The offset decision latched on a strobe and the live step register can both change at the same clock edge. The bench changes the on-counts on every cycle, including the strobe cycles. It also places directed vectors for mode 0, mode 1, a clamped mode 0 and an odd negative gap on strobe edges. At every falling edge a behavioural model, kept in integers, is compared with all four outputs. Cycles without a strobe confirm that mode and offsets keep the last loaded values, while the step keeps following the on-counts.

// File: rtl/cmsl_pkg.sv
`timescale 1ns/1ps
package cmsl_pkg;
  typedef enum logic [1:0] {
    MODE_LO_PEAK = 2'd0,
    MODE_UP_PEAK = 2'd1,
    MODE_IDLE    = 2'd2
  } cm_mode_e;
endpackage

// File: rtl/cmsl_arm_stats.sv
`timescale 1ns/1ps
module cmsl_arm_stats #(
  parameter int N_SM   = 4,
  parameter int FRAC_W = 8,
  localparam int CNT_W = $clog2(N_SM + 1),
  localparam int SUM_W = $clog2(3 * N_SM + 1),
  localparam int REM_W = FRAC_W + 1
) (
  input  logic [2:0][CNT_W-1:0] base_i,
  input  logic [2:0][REM_W-1:0] rem_i,
  output logic [SUM_W-1:0]      sum_o,
  output logic [REM_W-1:0]      rmax_o,
  output logic [REM_W-1:0]      rmin_o
);
  always_comb begin
    sum_o  = '0;
    rmax_o = rem_i[0];
    rmin_o = rem_i[0];
    for (int k = 0; k < 3; k++) begin
      sum_o = sum_o + SUM_W'(base_i[k]);
      if (rem_i[k] > rmax_o) rmax_o = rem_i[k];
      if (rem_i[k] < rmin_o) rmin_o = rem_i[k];
    end
  end

  always_comb begin
    a_r6_minmax_order: assert (rmin_o <= rmax_o);
  end
endmodule

// File: rtl/cmsl_offset_calc.sv
`timescale 1ns/1ps
module cmsl_offset_calc
  import cmsl_pkg::*;
#(
  parameter int N_SM   = 4,
  parameter int FRAC_W = 8,
  localparam int SUM_W = $clog2(3 * N_SM + 1),
  localparam int REM_W = FRAC_W + 1,
  localparam int OFF_W = FRAC_W + 2
) (
  input  logic [SUM_W-1:0]        sum_u_i,
  input  logic [SUM_W-1:0]        sum_l_i,
  input  logic [REM_W-1:0]        max_u_i,
  input  logic [REM_W-1:0]        min_u_i,
  input  logic [REM_W-1:0]        max_l_i,
  input  logic [REM_W-1:0]        min_l_i,
  output cm_mode_e                mode_o,
  output logic signed [OFF_W-1:0] off_u_o,
  output logic signed [OFF_W-1:0] off_l_o
);
  localparam logic signed [OFF_W-1:0] ONE_S = OFF_W'(1 << FRAC_W);

  logic signed [SUM_W:0]   d;
  logic signed [OFF_W-1:0] smax_u, smin_u, smax_l, smin_l;
  logic signed [OFF_W-1:0] gap, half, raw_u, raw_l;

  function automatic logic signed [OFF_W-1:0] clamp_off(
    input logic signed [OFF_W-1:0] v,
    input logic signed [OFF_W-1:0] lo,
    input logic signed [OFF_W-1:0] hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction

  always_comb begin
    d      = $signed({1'b0, sum_l_i}) - $signed({1'b0, sum_u_i});
    smax_u = $signed({1'b0, max_u_i});
    smin_u = $signed({1'b0, min_u_i});
    smax_l = $signed({1'b0, max_l_i});
    smin_l = $signed({1'b0, min_l_i});
    // lower peak coinciding with upper trough
    if (d == -1 && max_u_i > min_l_i)     mode_o = MODE_LO_PEAK;
    else if (d == 1 && max_l_i > min_u_i) mode_o = MODE_UP_PEAK;
    else                                  mode_o = MODE_IDLE;
    gap  = smin_u - smax_l;
    half = gap >>> 1;
    case (mode_o)
      MODE_LO_PEAK: raw_u = half;
      MODE_UP_PEAK: raw_u = -half;
      default:      raw_u = '0;
    endcase
    raw_l   = -raw_u;
    off_u_o = clamp_off(raw_u, -smin_u, ONE_S - smax_u);
    off_l_o = clamp_off(raw_l, -smin_l, ONE_S - smax_l);
  end

  always_comb begin
    if (mode_o != MODE_IDLE && max_u_i <= REM_W'(1 << FRAC_W) && max_l_i <= REM_W'(1 << FRAC_W)) begin
      a_r7_upper_in_range: assert (smin_u + off_u_o >= 0 && smax_u + off_u_o <= ONE_S);
      a_r7_lower_in_range: assert (smin_l + off_l_o >= 0 && smax_l + off_l_o <= ONE_S);
    end
  end
endmodule

// File: rtl/cmsl_step_meter.sv
`timescale 1ns/1ps
module cmsl_step_meter #(
  parameter int SUM_W = 4,
  localparam int STEP_W = SUM_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SUM_W-1:0]         on_u_i,
  input  logic [SUM_W-1:0]         on_l_i,
  output logic signed [STEP_W-1:0] step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_o <= '0;
    else         step_o <= $signed({1'b0, on_l_i}) - $signed({1'b0, on_u_i});
  end

  a_r2_step_positive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_l_i > on_u_i) |=> (step_o > 0));
  a_r2_step_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_l_i < on_u_i) |=> (step_o < 0));
endmodule

// File: rtl/peak_cm_limiter.sv
`timescale 1ns/1ps
module peak_cm_limiter
  import cmsl_pkg::*;
#(
  parameter int N_SM   = 4,
  parameter int FRAC_W = 8,
  localparam int CNT_W  = $clog2(N_SM + 1),
  localparam int SUM_W  = $clog2(3 * N_SM + 1),
  localparam int REM_W  = FRAC_W + 1,
  localparam int OFF_W  = FRAC_W + 2,
  localparam int STEP_W = SUM_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [2:0][CNT_W-1:0]    base_u_i,
  input  logic [2:0][CNT_W-1:0]    base_l_i,
  input  logic [2:0][REM_W-1:0]    rem_u_i,
  input  logic [2:0][REM_W-1:0]    rem_l_i,
  input  logic [SUM_W-1:0]         on_cnt_u_i,
  input  logic [SUM_W-1:0]         on_cnt_l_i,
  output logic [1:0]               mode_o,
  output logic signed [OFF_W-1:0]  off_u_o,
  output logic signed [OFF_W-1:0]  off_l_o,
  output logic signed [STEP_W-1:0] cm_step_o
);
  logic [1:0][SUM_W-1:0] sum;
  logic [1:0][REM_W-1:0] rmax, rmin;

  // index 0 = upper arm, 1 = lower arm
  for (genvar a = 0; a < 2; a++) begin : g_arm
    cmsl_arm_stats #(.N_SM(N_SM), .FRAC_W(FRAC_W)) stats_i (
      .base_i (a == 0 ? base_u_i : base_l_i),
      .rem_i  (a == 0 ? rem_u_i  : rem_l_i),
      .sum_o  (sum[a]),
      .rmax_o (rmax[a]),
      .rmin_o (rmin[a])
    );
  end

  cm_mode_e                mode_d;
  logic signed [OFF_W-1:0] off_u_d, off_l_d;

  cmsl_offset_calc #(.N_SM(N_SM), .FRAC_W(FRAC_W)) calc_i (
    .sum_u_i (sum[0]),
    .sum_l_i (sum[1]),
    .max_u_i (rmax[0]),
    .min_u_i (rmin[0]),
    .max_l_i (rmax[1]),
    .min_l_i (rmin[1]),
    .mode_o  (mode_d),
    .off_u_o (off_u_d),
    .off_l_o (off_l_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MODE_IDLE;
      off_u_o <= '0;
      off_l_o <= '0;
    end else if (strobe_i) begin
      mode_o  <= mode_d;
      off_u_o <= off_u_d;
      off_l_o <= off_l_d;
    end
  end

  cmsl_step_meter #(.SUM_W(SUM_W)) meter_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .on_u_i (on_cnt_u_i),
    .on_l_i (on_cnt_l_i),
    .step_o (cm_step_o)
  );

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(mode_o) && $stable(off_u_o) && $stable(off_l_o)));
  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_IDLE) |-> (off_u_o == 0 && off_l_o == 0));
  a_r3_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
  a_r6_opposite_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_u_o == 0 || off_l_o == 0 || off_u_o[OFF_W-1] != off_l_o[OFF_W-1]));
endmodule

// File: tb/peak_cm_limiter_tb_top.sv
`timescale 1ns/1ps
module peak_cm_limiter_tb_top;
  localparam int N_SM   = 4;
  localparam int FRAC_W = 8;
  localparam int CNT_W  = 3;
  localparam int SUM_W  = 4;
  localparam int REM_W  = 9;
  localparam int OFF_W  = 10;
  localparam int STEP_W = 5;
  localparam int ONE    = 1 << FRAC_W;

  logic clk, rst_n, strobe;
  logic [2:0][CNT_W-1:0] base_u, base_l;
  logic [2:0][REM_W-1:0] rem_u, rem_l;
  logic [SUM_W-1:0] on_u, on_l;
  logic [1:0] mode;
  logic signed [OFF_W-1:0] off_u, off_l;
  logic signed [STEP_W-1:0] step;

  peak_cm_limiter #(.N_SM(N_SM), .FRAC_W(FRAC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe),
    .base_u_i(base_u), .base_l_i(base_l), .rem_u_i(rem_u), .rem_l_i(rem_l),
    .on_cnt_u_i(on_u), .on_cnt_l_i(on_l),
    .mode_o(mode), .off_u_o(off_u), .off_l_o(off_l), .cm_step_o(step)
  );

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  int total = 0, bad = 0;
  bit done = 0;
  int bu[3], bl[3], ru[3], rl[3];
  int exp_mode = 2, exp_ou = 0, exp_ol = 0, exp_step = 0;
  bit exp_clamped = 0;

  function automatic int floor_half(int v);
    if (v >= 0) return v / 2;
    return -((-v + 1) / 2);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_strobe();
    int su = 0, sl = 0, mxu = 0, mnu = ONE, mxl = 0, mnl = ONE, d, m, ru_o, rl_o, c;
    for (int k = 0; k < 3; k++) begin
      su += bu[k]; sl += bl[k];
      if (ru[k] > mxu) mxu = ru[k];
      if (ru[k] < mnu) mnu = ru[k];
      if (rl[k] > mxl) mxl = rl[k];
      if (rl[k] < mnl) mnl = rl[k];
    end
    d = sl - su;
    if (d == -1 && mxu > mnl) exp_mode = 0;
    else if (d == 1 && mxl > mnu) exp_mode = 1;
    else exp_mode = 2;
    m = floor_half(mnu - mxl);
    ru_o = (exp_mode == 0) ? m : (exp_mode == 1) ? -m : 0;
    rl_o = -ru_o;
    exp_clamped = 0;
    c = ru_o;
    if (c < -mnu) c = -mnu;
    if (c > ONE - mxu) c = ONE - mxu;
    if (c != ru_o) exp_clamped = 1;
    exp_ou = c;
    c = rl_o;
    if (c < -mnl) c = -mnl;
    if (c > ONE - mxl) c = ONE - mxl;
    if (c != rl_o) exp_clamped = 1;
    exp_ol = c;
  endtask

  // called at a falling edge: drive, model next state, compare at next falling edge
  task automatic cycle(bit stb, int ou, int ol);
    string mt, ot, st;
    for (int k = 0; k < 3; k++) begin
      base_u[k] = CNT_W'(bu[k]); base_l[k] = CNT_W'(bl[k]);
      rem_u[k]  = REM_W'(ru[k]); rem_l[k]  = REM_W'(rl[k]);
    end
    on_u = SUM_W'(ou); on_l = SUM_W'(ol); strobe = stb;
    if (stb) model_strobe();
    exp_step = ol - ou;
    @(negedge clk);
    mt = !stb ? "R8" : (exp_mode == 0) ? "R3" : (exp_mode == 1) ? "R4" : "R5";
    ot = !stb ? "R8" : exp_clamped ? "R7" : (exp_mode == 2) ? "R5" : "R6";
    st = stb ? "R9" : "R2"; // R9: step checked in the same cycle as a strobe load
    check(mt, "mode", int'(mode), exp_mode);
    check(ot, "off_u", int'(off_u), exp_ou);
    check(ot, "off_l", int'(off_l), exp_ol);
    check(st, "cm_step", int'(step), exp_step);
  endtask

  task automatic setv(int a0, int a1, int a2, int b0, int b1, int b2,
                      int c0, int c1, int c2, int e0, int e1, int e2);
    bu = '{a0, a1, a2}; bl = '{b0, b1, b2};
    ru = '{c0, c1, c2}; rl = '{e0, e1, e2};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; strobe = 0; on_u = '0; on_l = '0;
    base_u = '0; base_l = '0; rem_u = '0; rem_l = '0;
    repeat (3) @(negedge clk);
    on_u = 4'd3; on_l = 4'd9; strobe = 1;
    setv(2,1,2, 3,1,0, 250,200,220, 5,40,10);
    for (int k = 0; k < 3; k++) begin
      base_u[k] = CNT_W'(bu[k]); base_l[k] = CNT_W'(bl[k]);
      rem_u[k] = REM_W'(ru[k]); rem_l[k] = REM_W'(rl[k]);
    end
    @(negedge clk);
    check("R1", "mode", int'(mode), 2);
    check("R1", "off_u", int'(off_u), 0);
    check("R1", "off_l", int'(off_l), 0);
    check("R1", "cm_step", int'(step), 0);
    strobe = 0;
    rst_n = 1;
    @(negedge clk);
    // R3 + R7: lower-peak case, both offsets clamped
    setv(2,1,2, 3,1,0, 250,200,220, 5,40,10);   cycle(1, 12, 0);
    // R8: hold with changed inputs
    setv(0,0,0, 4,4,4, 0,0,0, 256,256,256);     cycle(0, 0, 12);
    // R3 + R6: unclamped
    setv(2,1,2, 3,1,0, 100,120,110, 30,60,50);  cycle(1, 5, 5);
    // R4 + R6: upper-peak case
    setv(1,1,2, 2,2,1, 60,70,100, 180,90,120);  cycle(1, 7, 2);
    // R5: d = -1 but comparison fails
    setv(2,1,2, 3,1,0, 10,20,30, 40,50,60);     cycle(1, 0, 0);
    // R4 + R6: odd negative gap floors
    setv(1,1,2, 2,2,1, 50,50,50, 57,57,57);     cycle(1, 4, 11);
    // R5: equal sums
    setv(2,2,2, 2,2,2, 10,200,30, 90,5,250);    cycle(1, 12, 12);
    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < 3; k++) begin
        bu[k] = $urandom_range(N_SM, 0); bl[k] = $urandom_range(N_SM, 0);
        ru[k] = $urandom_range(ONE, 0);  rl[k] = $urandom_range(ONE, 0);
      end
      cycle($urandom_range(3, 0) == 0, $urandom_range(3 * N_SM, 0), $urandom_range(3 * N_SM, 0));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule